// File: doc/BRIEF.md
# Bidirectional Latched Transceiver with Byte Parity

This block moves 16-bit words between an A side and a B side. Each direction has its own storage stage. The stage can be transparent, so the output follows the input with no clock. It can hold a stored word. It can also capture a new word on each rising edge of that direction's own clock. Two parity bits travel with each word, and each parity bit covers one byte.

On the way from A to B, the block can work in one of two modes. In generate mode it builds fresh parity from the data it drives. In check mode it passes the incoming parity through and verifies it. The B-to-A direction always checks. One odd/even select sets the parity sense for both directions.

Each direction reports a byte-parity failure on one active-low flag. The flag is paired with a drive-enable so that several flags can share a wired-OR line. A direction whose output enable is off releases its flag. It also reports its data as not driven and keeps its stored word.

Top module: `duplex_parity_xcvr`

## Requirements
- R1: While a direction's latch enable is high, its data and parity outputs equal its current data and parity inputs in the same cycle, with no clock edge needed.
- R2: While a direction's latch enable is low, its outputs show the word captured at the most recent rising edge of that direction's clock. With no edge, the outputs hold that word even when the inputs change.
- R3: A rising clock edge with rst_n low clears that direction's stored data and parity to zero.
- R4: With gen_sel high (generate mode), b_par_out[0] equals the XOR of b_data_out[7:0] XOR odd_sel, and b_par_out[1] equals the XOR of b_data_out[15:8] XOR odd_sel.
- R5: With gen_sel low (check mode), b_par_out passes the stored A parity through. The A-to-B error condition holds when a byte fails its parity check. A byte fails when the XOR of its eight driven data bits and its driven parity bit differs from odd_sel.
- R6: The B-to-A direction always passes the B parity through and applies the same check to a_data_out and a_par_out, whatever the value of gen_sel.
- R7: odd_sel is shared by both directions. 0 selects even parity (data XOR parity is 0) and 1 selects odd parity (data XOR parity is 1).
- R8: An error flag is active (err_*_n low, err_*_drv high) exactly when its direction's output enable is high and that direction has a byte error. Otherwise the flag is released (err_*_n high, err_*_drv low). In generate mode the A-to-B flag stays released.
- R9: With a direction's output enable low, its data-drive output is low and its flag is released. The stored word is kept and reappears when the enable returns high.
- R10: The latch enable, clock and output enable of one direction have no effect on the outputs of the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock for the A-to-B stage |
| clk_ba | input | 1 | Capture clock for the B-to-A stage |
| rst_n | input | 1 | Synchronous active-low reset, sampled by each direction's clock |
| le_ab | input | 1 | A-to-B latch enable, high = transparent |
| le_ba | input | 1 | B-to-A latch enable, high = transparent |
| oe_ab | input | 1 | A-to-B output enable, high = drive |
| oe_ba | input | 1 | B-to-A output enable, high = drive |
| gen_sel | input | 1 | A-to-B parity mode, 1 = generate, 0 = check |
| odd_sel | input | 1 | Parity sense for both directions, 1 = odd, 0 = even |
| a_data_in | input | 16 | Data arriving on the A side |
| a_par_in | input | 2 | Parity arriving on the A side, bit k covers byte k |
| b_data_in | input | 16 | Data arriving on the B side |
| b_par_in | input | 2 | Parity arriving on the B side, bit k covers byte k |
| b_data_out | output | 16 | Data presented to the B side |
| b_par_out | output | 2 | Parity presented to the B side |
| b_drv | output | 1 | B-side data and parity are driven |
| err_ab_n | output | 1 | A-to-B parity error flag, active low |
| err_ab_drv | output | 1 | A-to-B flag pulls its line low |
| a_data_out | output | 16 | Data presented to the A side |
| a_par_out | output | 2 | Parity presented to the A side |
| a_drv | output | 1 | A-side data and parity are driven |
| err_ba_n | output | 1 | B-to-A parity error flag, active low |
| err_ba_drv | output | 1 | B-to-A flag pulls its line low |

## Verification
In transparent mode, the parity outputs, the flags and the drive outputs are combinational and change in the same cycle as their inputs. A word captured in clocked mode becomes visible just after the rising edge of that direction's clock, one edge after the inputs are set. The bench changes inputs on the falling edge and gates each direction's clock so that a step can have no edge at all. Its scoreboard compares each expected item 5 ns after the next rising edge, by which time both the combinational results and any newly captured word have settled.

// File: rtl/xcvr_pkg.sv
// Shared encodings for the duplex parity transceiver.
// Assumes: single-bit selects, 1 = odd sense / generate mode.
package xcvr_pkg;

    typedef enum logic {
        SENSE_EVEN = 1'b0,
        SENSE_ODD  = 1'b1
    } par_sense_e;

    typedef enum logic {
        AB_CHECK    = 1'b0,
        AB_GENERATE = 1'b1
    } ab_mode_e;

endpackage

// File: rtl/xcvr_stage.sv
// Storage stage for one direction: a register that loads on each rising
// clock edge, bypassed combinationally while the latch enable is high.
// Assumes: the clock is stopped by its source to hold a word (latched mode).
module xcvr_stage #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] held;

    // Capture the input word on each edge; clear under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) held <= '0;
        else        held <= d_in;
    end

    // Transparent bypass while le is high, stored word otherwise.
    assign q_out = le ? d_in : held;

endmodule

// File: rtl/xcvr_byte_parity.sv
// Per-byte parity unit: produces a parity bit for each byte and a mismatch
// bit for each byte against supplied parity, in the selected sense.
// Assumes: parity bit k covers data bits [k*BW +: BW].
module xcvr_byte_parity
    import xcvr_pkg::*;
#(
    parameter int BYTES = 2,
    parameter int BW    = 8,
    localparam int DW   = BYTES * BW
) (
    input  logic [DW-1:0]    data,
    input  logic [BYTES-1:0] par_in,
    input  par_sense_e       sense,
    output logic [BYTES-1:0] par_gen,
    output logic [BYTES-1:0] byte_err
);

    logic sense_bit;
    assign sense_bit = logic'(sense);

    for (genvar g = 0; g < BYTES; g++) begin : g_byte
        logic red;
        // Reduction XOR of one byte.
        assign red         = ^data[g*BW +: BW];
        // Parity bit that makes the byte total equal the sense.
        assign par_gen[g]  = red ^ sense_bit;
        // Mismatch when byte total differs from the sense.
        assign byte_err[g] = red ^ par_in[g] ^ sense_bit;
    end

endmodule

// File: rtl/xcvr_dir.sv
// One transfer direction: storage stage, parity generate/check and an
// open-drain style error flag gated by the output enable.
// Assumes: CAN_GEN = 0 builds a check-only direction and ignores gen.
module xcvr_dir
    import xcvr_pkg::*;
#(
    parameter int BYTES   = 2,
    parameter int BW      = 8,
    parameter bit CAN_GEN = 1'b1,
    localparam int DW     = BYTES * BW,
    localparam int SW     = DW + BYTES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic             oe,
    input  logic             gen,
    input  par_sense_e       sense,
    input  logic [DW-1:0]    d_in,
    input  logic [BYTES-1:0] p_in,
    output logic [DW-1:0]    d_out,
    output logic [BYTES-1:0] p_out,
    output logic             drv,
    output logic             err_n,
    output logic             err_drv
);

    logic [SW-1:0]    stage_q;
    logic [DW-1:0]    st_data;
    logic [BYTES-1:0] st_par;
    logic [BYTES-1:0] par_gen;
    logic [BYTES-1:0] byte_err;
    logic             gen_act;
    logic             any_err;

    xcvr_stage #(.W(SW)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le),
        .d_in  ({p_in, d_in}),
        .q_out (stage_q)
    );

    assign st_data = stage_q[DW-1:0];
    assign st_par  = stage_q[SW-1:DW];

    xcvr_byte_parity #(.BYTES(BYTES), .BW(BW)) u_par (
        .data     (st_data),
        .par_in   (st_par),
        .sense    (sense),
        .par_gen  (par_gen),
        .byte_err (byte_err)
    );

    // Generate mode only exists where the variant allows it.
    assign gen_act = CAN_GEN && gen;

    // Select outgoing parity and the direction's error condition.
    always_comb begin
        d_out   = st_data;
        p_out   = gen_act ? par_gen : st_par;
        any_err = gen_act ? 1'b0 : |byte_err;
    end

    // Flag drives low only while enabled and in error.
    assign drv     = oe;
    assign err_drv = any_err & oe;
    assign err_n   = ~err_drv;

endmodule

// File: rtl/duplex_parity_xcvr.sv
// Top level: A-to-B direction with generate/check parity and B-to-A
// direction with check-only parity, sharing one parity sense select.
// Assumes: each direction is clocked and enabled independently.
module duplex_parity_xcvr
    import xcvr_pkg::*;
#(
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8,
    localparam int DW    = BYTES * BYTE_W
) (
    input  logic             clk_ab,
    input  logic             clk_ba,
    input  logic             rst_n,
    input  logic             le_ab,
    input  logic             le_ba,
    input  logic             oe_ab,
    input  logic             oe_ba,
    input  logic             gen_sel,
    input  logic             odd_sel,
    input  logic [DW-1:0]    a_data_in,
    input  logic [BYTES-1:0] a_par_in,
    input  logic [DW-1:0]    b_data_in,
    input  logic [BYTES-1:0] b_par_in,
    output logic [DW-1:0]    b_data_out,
    output logic [BYTES-1:0] b_par_out,
    output logic             b_drv,
    output logic             err_ab_n,
    output logic             err_ab_drv,
    output logic [DW-1:0]    a_data_out,
    output logic [BYTES-1:0] a_par_out,
    output logic             a_drv,
    output logic             err_ba_n,
    output logic             err_ba_drv
);

    par_sense_e sense;
    assign sense = par_sense_e'(odd_sel);

    xcvr_dir #(.BYTES(BYTES), .BW(BYTE_W), .CAN_GEN(1'b1)) u_ab (
        .clk     (clk_ab),
        .rst_n   (rst_n),
        .le      (le_ab),
        .oe      (oe_ab),
        .gen     (gen_sel),
        .sense   (sense),
        .d_in    (a_data_in),
        .p_in    (a_par_in),
        .d_out   (b_data_out),
        .p_out   (b_par_out),
        .drv     (b_drv),
        .err_n   (err_ab_n),
        .err_drv (err_ab_drv)
    );

    xcvr_dir #(.BYTES(BYTES), .BW(BYTE_W), .CAN_GEN(1'b0)) u_ba (
        .clk     (clk_ba),
        .rst_n   (rst_n),
        .le      (le_ba),
        .oe      (oe_ba),
        .gen     (gen_sel),
        .sense   (sense),
        .d_in    (b_data_in),
        .p_in    (b_par_in),
        .d_out   (a_data_out),
        .p_out   (a_par_out),
        .drv     (a_drv),
        .err_n   (err_ba_n),
        .err_drv (err_ba_drv)
    );

endmodule

// File: rtl/xcvr_checker.sv
// Property checker for duplex_parity_xcvr, attached with bind below.
// Assumes: properties sample on each direction's own clock.
module xcvr_checker #(
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8,
    localparam int DW    = BYTES * BYTE_W
) (
    input logic             clk_ab,
    input logic             clk_ba,
    input logic             rst_n,
    input logic             le_ab,
    input logic             oe_ab,
    input logic             oe_ba,
    input logic             gen_sel,
    input logic             odd_sel,
    input logic [DW-1:0]    a_data_in,
    input logic [DW-1:0]    b_data_out,
    input logic [BYTES-1:0] b_par_out,
    input logic             err_ab_drv,
    input logic [DW-1:0]    a_data_out,
    input logic [BYTES-1:0] a_par_out,
    input logic             err_ba_n,
    input logic             err_ba_drv
);

    logic [BYTES-1:0] exp_b_par;
    logic [BYTES-1:0] a_side_bad;

    // Expected generated parity and B-to-A byte mismatches from the ports.
    always_comb begin
        for (int k = 0; k < BYTES; k++) begin
            exp_b_par[k]  = (^b_data_out[k*BYTE_W +: BYTE_W]) ^ odd_sel;
            a_side_bad[k] = ((^a_data_out[k*BYTE_W +: BYTE_W]) ^ a_par_out[k]) != odd_sel;
        end
    end

    AST_TRANSPARENT_FOLLOWS: assert property (@(posedge clk_ab) disable iff (!rst_n)
        le_ab |-> b_data_out == a_data_in);                                  // R1

    AST_CLOCKED_CAPTURE: assert property (@(posedge clk_ab) disable iff (!rst_n)
        (!le_ab && $past(rst_n)) |-> b_data_out == $past(a_data_in));        // R2

    AST_GEN_PARITY_MATCH: assert property (@(posedge clk_ab) disable iff (!rst_n)
        gen_sel |-> b_par_out == exp_b_par);                                 // R4

    AST_GEN_FLAG_QUIET: assert property (@(posedge clk_ab) disable iff (!rst_n)
        gen_sel |-> !err_ab_drv);                                            // R8

    AST_AB_FLAG_NEEDS_OE: assert property (@(posedge clk_ab) disable iff (!rst_n)
        err_ab_drv |-> oe_ab);                                               // R9

    AST_BA_FLAG_NEEDS_OE: assert property (@(posedge clk_ba) disable iff (!rst_n)
        err_ba_drv |-> oe_ba);                                               // R9

    AST_BA_ALWAYS_CHECKS: assert property (@(posedge clk_ba) disable iff (!rst_n)
        (oe_ba && |a_side_bad) |-> (!err_ba_n && err_ba_drv));               // R6

endmodule

bind duplex_parity_xcvr xcvr_checker #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_chk (
    .clk_ab     (clk_ab),
    .clk_ba     (clk_ba),
    .rst_n      (rst_n),
    .le_ab      (le_ab),
    .oe_ab      (oe_ab),
    .oe_ba      (oe_ba),
    .gen_sel    (gen_sel),
    .odd_sel    (odd_sel),
    .a_data_in  (a_data_in),
    .b_data_out (b_data_out),
    .b_par_out  (b_par_out),
    .err_ab_drv (err_ab_drv),
    .a_data_out (a_data_out),
    .a_par_out  (a_par_out),
    .err_ba_n   (err_ba_n),
    .err_ba_drv (err_ba_drv)
);

// File: tb/duplex_parity_xcvr_test.sv
// Scoreboard bench: step() drives on the falling edge and queues the
// expected outputs; the monitor compares them 5 ns after the next rising edge.
module duplex_parity_xcvr_test;

    logic clk = 1'b0;
    always #10 clk = ~clk;                 // 50 MHz

    logic run_ab = 1'b1, run_ba = 1'b1;    // gate the direction clocks
    logic clk_ab, clk_ba;
    assign clk_ab = clk & run_ab;
    assign clk_ba = clk & run_ba;

    logic rst_n = 1'b0;
    logic le_ab = 0, le_ba = 0, oe_ab = 1, oe_ba = 1, gen_sel = 0, odd_sel = 0;
    logic [15:0] a_data_in = '0, b_data_in = '0;
    logic [1:0]  a_par_in = '0, b_par_in = '0;
    logic [15:0] b_data_out, a_data_out;
    logic [1:0]  b_par_out, a_par_out;
    logic b_drv, err_ab_n, err_ab_drv, a_drv, err_ba_n, err_ba_drv;

    duplex_parity_xcvr uut (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
        .le_ab(le_ab), .le_ba(le_ba), .oe_ab(oe_ab), .oe_ba(oe_ba),
        .gen_sel(gen_sel), .odd_sel(odd_sel),
        .a_data_in(a_data_in), .a_par_in(a_par_in),
        .b_data_in(b_data_in), .b_par_in(b_par_in),
        .b_data_out(b_data_out), .b_par_out(b_par_out), .b_drv(b_drv),
        .err_ab_n(err_ab_n), .err_ab_drv(err_ab_drv),
        .a_data_out(a_data_out), .a_par_out(a_par_out), .a_drv(a_drv),
        .err_ba_n(err_ba_n), .err_ba_drv(err_ba_drv)
    );

    typedef struct {
        string       req;
        logic [15:0] bd;  logic [1:0] bp;  logic bdrv; logic eabn; logic eabd;
        logic [15:0] ad;  logic [1:0] ap;  logic adrv; logic eban; logic ebad;
    } exp_t;

    exp_t exp_q[$];
    int vectors = 0, miscompares = 0;
    bit done = 0;

    // Bench model of the stored words
    logic [15:0] m_ab_d = '0, m_ba_d = '0;
    logic [1:0]  m_ab_p = '0, m_ba_p = '0;

    function automatic logic [1:0] good_par(input logic [15:0] d, input logic odd);
        return {(^d[15:8]) ^ odd, (^d[7:0]) ^ odd};
    endfunction

    function automatic logic any_bad(input logic [15:0] d, input logic [1:0] p, input logic odd);
        return (((^d[7:0]) ^ p[0]) != odd) || (((^d[15:8]) ^ p[1]) != odd);
    endfunction

    // Queue the outputs expected after the coming rising edge, then advance.
    task automatic step(input string req);
        exp_t e;
        logic [15:0] sd; logic [1:0] sp;
        logic bad;
        if (run_ab) begin m_ab_d = rst_n ? a_data_in : '0; m_ab_p = rst_n ? a_par_in : '0; end
        if (run_ba) begin m_ba_d = rst_n ? b_data_in : '0; m_ba_p = rst_n ? b_par_in : '0; end
        e.req  = req;
        sd     = le_ab ? a_data_in : m_ab_d;
        sp     = le_ab ? a_par_in  : m_ab_p;
        e.bd   = sd;
        e.bp   = gen_sel ? good_par(sd, odd_sel) : sp;
        bad    = !gen_sel && any_bad(sd, sp, odd_sel);
        e.bdrv = oe_ab;
        e.eabd = bad && oe_ab;
        e.eabn = !e.eabd;
        sd     = le_ba ? b_data_in : m_ba_d;
        sp     = le_ba ? b_par_in  : m_ba_p;
        e.ad   = sd;
        e.ap   = sp;
        bad    = any_bad(sd, sp, odd_sel);
        e.adrv = oe_ba;
        e.ebad = bad && oe_ba;
        e.eban = !e.ebad;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic cmp(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Monitor: pop and compare once outputs have settled after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                cmp(e.req, "b_data_out", b_data_out, e.bd);
                cmp(e.req, "b_par_out",  16'(b_par_out), 16'(e.bp));
                cmp(e.req, "b_drv",      16'(b_drv), 16'(e.bdrv));
                cmp(e.req, "err_ab_n",   16'(err_ab_n), 16'(e.eabn));
                cmp(e.req, "err_ab_drv", 16'(err_ab_drv), 16'(e.eabd));
                cmp(e.req, "a_data_out", a_data_out, e.ad);
                cmp(e.req, "a_par_out",  16'(a_par_out), 16'(e.ap));
                cmp(e.req, "a_drv",      16'(a_drv), 16'(e.adrv));
                cmp(e.req, "err_ba_n",   16'(err_ba_n), 16'(e.eban));
                cmp(e.req, "err_ba_drv", 16'(err_ba_drv), 16'(e.ebad));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R3: reset clears both stores
        a_data_in = 16'hBEEF; b_data_in = 16'hCAFE; a_par_in = 2'b11; b_par_in = 2'b11;
        step("R3"); step("R3"); step("R3");
        rst_n = 1'b1;

        // R2 clocked capture, then hold with no edge
        a_data_in = 16'h1234; a_par_in = good_par(16'h1234, 1'b0);
        b_data_in = 16'h00FF; b_par_in = good_par(16'h00FF, 1'b0);
        step("R2");
        run_ab = 0; run_ba = 0;
        a_data_in = 16'h5A5A; b_data_in = 16'h7001;
        step("R2"); step("R2");

        // R1 transparent with clocks stopped
        le_ab = 1; a_data_in = 16'h8001; a_par_in = 2'b00;
        step("R1");
        le_ba = 1; b_data_in = 16'h0F0F; b_par_in = good_par(16'h0F0F, 1'b0);
        step("R1");
        le_ab = 0; le_ba = 0;
        step("R2");

        // R4 generate mode with bogus incoming parity, both senses (R7, R8)
        run_ab = 1; run_ba = 1; gen_sel = 1;
        a_data_in = 16'h0103; a_par_in = 2'b11;
        step("R4");
        odd_sel = 1;
        step("R7");
        a_data_in = 16'hFF00; a_par_in = 2'b00;
        step("R8");

        // R5 check mode: good, bad low byte, bad high byte
        gen_sel = 0; odd_sel = 0;
        b_data_in = 16'h0000; b_par_in = 2'b00;
        a_data_in = 16'h3C81; a_par_in = good_par(16'h3C81, 1'b0);
        step("R5");
        a_par_in = good_par(16'h3C81, 1'b0) ^ 2'b01;
        step("R5");
        a_par_in = good_par(16'h3C81, 1'b0) ^ 2'b10;
        step("R5");
        // R7: even-built parity seen under odd sense fails both sides
        odd_sel = 1; a_par_in = good_par(16'h3C81, 1'b0);
        step("R7");
        a_par_in = good_par(16'h3C81, 1'b1); b_par_in = good_par(16'h0000, 1'b1);
        step("R7");

        // R9 output enable off masks flag and keeps the store
        odd_sel = 0; a_par_in = 2'b01; a_data_in = 16'h2222;
        step("R8");
        oe_ab = 0;
        step("R9");
        run_ab = 0; a_data_in = 16'h9999; a_par_in = 2'b00;
        step("R9");
        oe_ab = 1;
        step("R9");

        // R6 B-to-A checks regardless of gen_sel
        run_ab = 1; run_ba = 1; gen_sel = 1;
        b_data_in = 16'h4433; b_par_in = good_par(16'h4433, 1'b0) ^ 2'b10;
        step("R6");
        b_par_in = good_par(16'h4433, 1'b0);
        step("R6");
        b_par_in = 2'b11; oe_ba = 0;
        step("R9");
        oe_ba = 1;
        step("R6");

        // R10 A-to-B controls leave B-to-A outputs alone
        run_ba = 0; b_data_in = 16'h1111;
        le_ab = 1; oe_ab = 0; a_data_in = 16'h6006;
        step("R10");
        le_ab = 0; run_ab = 1; oe_ab = 1; a_data_in = 16'h0770;
        step("R10");
        le_ba = 1;
        step("R10");

        // R3 reset again clears nonzero stores
        le_ba = 0; run_ba = 1; rst_n = 0; gen_sel = 0;
        step("R3");
        rst_n = 1; run_ab = 0; run_ba = 0;
        step("R3");

        @(posedge clk); #8;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule